// File: doc/BRIEF.md
# Programmable PRBS and Repetitive Pattern Generator

This block produces a serial test bit stream, one new bit for each clock on which the enable is high. It holds a 32-stage shift register and takes its output from a length tap chosen at run time. In PRBS mode the bit shifted back in is the XOR of the length tap and a second feedback tap. In repetitive mode the length tap alone is fed back, so a loaded word circulates. A fixed QRSS mode overrides both tap fields with the polynomial x^20 + x^17 + 1. It also forces a one onto the output whenever the next fourteen bits would all be zero.

The tap fields, mode select, QRSS enable and the 32-bit pattern word take effect only on a rising edge of the load input. Between loads they may change freely. Output inversion is a live control and is not part of the loaded configuration.

Stage positions are numbered 1 to 32. Position 1 is the stage a new bit enters on each shift, and each shift moves every bit one position up.

Top module: `pattern_gen`

## Requirements
- R1: After reset every stage holds one, the loaded configuration is all zero, and `bit_out` reads 1 while `invert` is low.
- R2: The length tap n is `len_sel` + 1. Outside QRSS mode, `bit_out` (before inversion) is the content of position n.
- R3: In PRBS mode (`rep_mode` = 0, `qrss_en` = 0), each enabled clock shifts the register up by one position. The XOR of position n and position y enters position 1, where y is `tap_sel` + 1.
- R4: In repetitive mode (`rep_mode` = 1, `qrss_en` = 0), a load copies `seed` into the register, with seed bit k going to position k+1. Position n alone is fed back and `tap_sel` has no effect, so the output repeats with period n.
- R5: With `qrss_en` = 1, the loaded `len_sel`, `tap_sel` and `rep_mode` are overridden: n = 20 and y = 17 in PRBS form.
- R6: In QRSS mode, `bit_out` (before inversion) is forced to 1 whenever positions 19 down to 6 (the next fourteen output bits) are all zero. No run of zeros is ever longer than 14.
- R7: Configuration and seed are captured only at a clock where `load` is 1 and was 0 at the previous clock. Holding `load` high captures nothing more. The capture happens regardless of `en`.
- R8: A load in PRBS or QRSS mode sets every stage to one.
- R9: In PRBS or QRSS mode, if positions 1 to n are all zero, the next clock sets every stage to one, whatever the value of `en`.
- R10: `invert` = 1 inverts `bit_out` in the same cycle, without a load.
- R11: With `en` low, and with no load and no lock-up, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance the register by one bit |
| len_sel | input | 5 | Length tap field (n = value + 1) |
| tap_sel | input | 5 | Feedback tap field (y = value + 1) |
| rep_mode | input | 1 | 1 = repetitive word, 0 = PRBS |
| qrss_en | input | 1 | Force QRSS polynomial and zero suppression |
| seed | input | 32 | Pattern word for repetitive mode |
| load | input | 1 | Rising edge captures configuration and seed |
| invert | input | 1 | Invert the output stream |
| bit_out | output | 1 | Serial test bit |

## Verification
A 7-stage maximal PRBS shows that the two taps are decoded correctly: a wrong tap breaks the 64-ones-per-127-bits balance and the exact bit match. Repetitive words of 8 and 32 bits, loaded with deliberately odd tap fields, show that the tap field is ignored and the seed is mapped in the right order. A long QRSS run tells the forced polynomial apart from the loaded fields, and its longest run of zeros shows whether suppression is working. Loads taken with the enable low, with the load input held high, and with equal taps that drive the register to all zeros separate edge detection, priority and lock-up recovery. Toggling the inversion control live shows that it acts in the same cycle.

// File: rtl/pattern_gen.sv
module pattern_gen #(
  parameter int W    = 32,
  parameter int SELW = 5,
  parameter int QLEN = 20,
  parameter int QTAP = 17,
  parameter int QRUN = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [SELW-1:0] len_sel,
  input  logic [SELW-1:0] tap_sel,
  input  logic            rep_mode,
  input  logic            qrss_en,
  input  logic [W-1:0]    seed,
  input  logic            load,
  input  logic            invert,
  output logic            bit_out
);
  localparam logic [SELW-1:0] QN = SELW'(QLEN - 1);
  localparam logic [SELW-1:0] QY = SELW'(QTAP - 1);

  logic [W-1:0]    sr;
  logic [W-1:0]    win_mask;
  logic [SELW-1:0] c_len, c_tap, n_idx, y_idx;
  logic            c_rep, c_qrss, load_q;
  logic            load_rise, rep_eff, lock, fb, run_zero, raw;

  assign load_rise = load & ~load_q;
  assign rep_eff   = c_rep & ~c_qrss;
  assign n_idx     = c_qrss ? QN : c_len;
  assign y_idx     = c_qrss ? QY : c_tap;

  always_comb
    for (int i = 0; i < W; i++) win_mask[i] = (i <= int'(n_idx));

  assign lock     = ~rep_eff & ((sr & win_mask) == '0);
  assign fb       = sr[n_idx] ^ (rep_eff ? 1'b0 : sr[y_idx]);
  assign run_zero = c_qrss & (sr[QLEN-2 -: QRUN] == '0);
  assign raw      = sr[n_idx] | run_zero;
  assign bit_out  = raw ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '1;
      load_q <= 1'b0;
      c_len  <= '0;
      c_tap  <= '0;
      c_rep  <= 1'b0;
      c_qrss <= 1'b0;
    end else begin
      load_q <= load;
      if (load_rise) begin
        c_len  <= len_sel;
        c_tap  <= tap_sel;
        c_rep  <= rep_mode;
        c_qrss <= qrss_en;
        sr     <= (rep_mode && !qrss_en) ? seed : '1;
      end else if (lock) begin
        sr <= '1;
      end else if (en) begin
        sr <= {sr[W-2:0], fb};
      end
    end
  end
endmodule

// File: rtl/pattern_gen_chk.sv
module pattern_gen_chk #(
  parameter int W    = 32,
  parameter int QLEN = 20,
  parameter int QRUN = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         load,
  input logic         load_q,
  input logic         lock,
  input logic         rep_mode,
  input logic         qrss_en,
  input logic         c_qrss,
  input logic [W-1:0] seed,
  input logic [W-1:0] sr,
  input logic         invert,
  input logic         bit_out
);
  logic rise;
  assign rise = load && !load_q;

  assert_seed_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise && (qrss_en || !rep_mode) |=> sr == '1);

  assert_seed_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise && rep_mode && !qrss_en |=> sr == $past(seed));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && !rise && !lock |=> sr[W-1:1] == $past(sr[W-2:0]));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !rise && !lock |=> $stable(sr));

  assert_reseed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !rise |=> sr == '1);

  assert_zero_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_qrss && (sr[QLEN-2 -: QRUN] == '0) |-> (bit_out ^ invert));

  assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load && load_q && !lock && !en |=> $stable(sr));
endmodule

bind pattern_gen pattern_gen_chk #(.W(W), .QLEN(QLEN), .QRUN(QRUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .load(load), .load_q(load_q),
  .lock(lock), .rep_mode(rep_mode), .qrss_en(qrss_en), .c_qrss(c_qrss),
  .seed(seed), .sr(sr), .invert(invert), .bit_out(bit_out)
);

// File: tb/pattern_gen_tb.sv
`timescale 1ns/1ps
module pattern_gen_tb;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, rep_mode = 1'b0, qrss_en = 1'b0;
  logic        load = 1'b0, invert = 1'b0, bit_out;
  logic [4:0]  len_sel = '0, tap_sel = '0;
  logic [31:0] seed = '0;

  pattern_gen u_dut (.clk(clk), .rst_n(rst_n), .en(en), .len_sel(len_sel),
    .tap_sel(tap_sel), .rep_mode(rep_mode), .qrss_en(qrss_en), .seed(seed),
    .load(load), .invert(invert), .bit_out(bit_out));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_sr;
  logic [4:0]  m_len, m_tap;
  logic        m_rep, m_qrss, m_lq;
  logic        q_exp[$];
  string       q_tag[$];
  string       cur = "R1";
  logic        hist[$];
  bit          track_run = 1'b0;
  int          run = 0, max_run = 0;

  function automatic int nn();
    return m_qrss ? 20 : int'(m_len) + 1;
  endfunction

  function automatic logic exp_bit();
    logic r;
    r = m_sr[nn()-1];
    if (m_qrss && m_sr[18:5] == 14'd0) r = 1'b1;
    return r ^ invert;
  endfunction

  task automatic model_reset();
    m_sr = '1; m_len = '0; m_tap = '0; m_rep = 1'b0; m_qrss = 1'b0; m_lq = 1'b0;
  endtask

  task automatic model_edge();
    logic rep, zero, f;
    int n, y;
    rep = m_rep & ~m_qrss;
    n = nn();
    y = m_qrss ? 17 : int'(m_tap) + 1;
    zero = 1'b1;
    for (int i = 0; i < n; i++) if (m_sr[i]) zero = 1'b0;
    if (load && !m_lq) begin
      m_len = len_sel; m_tap = tap_sel; m_rep = rep_mode; m_qrss = qrss_en;
      m_sr = (rep_mode && !qrss_en) ? seed : '1;
    end else if (!rep && zero) begin
      m_sr = '1;
    end else if (en) begin
      f = rep ? m_sr[n-1] : (m_sr[n-1] ^ m_sr[y-1]);
      m_sr = {m_sr[30:0], f};
    end
    m_lq = load;
  endtask

  task automatic step();
    q_exp.push_back(exp_bit());
    q_tag.push_back(cur);
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic steps(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic do_load(input bit rep, input bit q, input logic [4:0] l,
                         input logic [4:0] t, input logic [31:0] s);
    rep_mode = rep; qrss_en = q; len_sel = l; tap_sel = t; seed = s;
    load = 1'b0; step();
    load = 1'b1; step();
    steps(3);
    load = 1'b0;
    len_sel = ~l; tap_sel = ~t; seed = ~s; rep_mode = ~rep; qrss_en = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(bit_out === e, t, int'(bit_out), int'(e));
      hist.push_back(bit_out);
      if (track_run) begin
        run = (bit_out == 1'b0) ? run + 1 : 0;
        if (run > max_run) max_run = run;
      end
    end
  end

  initial begin
    int ones;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1.5;
    check(bit_out === 1'b1, "R1", int'(bit_out), 1);
    cur = "R11"; en = 1'b0; steps(5);

    cur = "R8"; en = 1'b1;
    do_load(1'b0, 1'b0, 5'd6, 5'd5, 32'h0);
    cur = "R2"; hist.delete(); steps(127);
    ones = 0;
    foreach (hist[i]) ones += int'(hist[i]);
    check(ones == 64, "R3", ones, 64);
    cur = "R3"; steps(200);

    cur = "R11";
    for (int i = 0; i < 40; i++) begin en = i[0] & i[2]; step(); end
    en = 1'b1;

    cur = "R7"; en = 1'b0;
    do_load(1'b0, 1'b0, 5'd14, 5'd13, 32'h0);
    en = 1'b1; load = 1'b1; len_sel = 5'd3; tap_sel = 5'd1; steps(60);
    load = 1'b0; steps(5);

    cur = "R4";
    do_load(1'b1, 1'b0, 5'd7, 5'd2, 32'h0000_00A5);
    hist.delete(); steps(24);
    for (int i = 0; i < 8; i++)
      check(hist[i] === hist[i+8] && hist[i] === hist[i+16], "R4", int'(hist[i+8]), int'(hist[i]));
    do_load(1'b1, 1'b0, 5'd31, 5'd31, 32'hDEAD_BEEF);
    steps(70);

    cur = "R10";
    for (int i = 0; i < 20; i++) begin invert = i[1]; step(); end
    invert = 1'b0;

    cur = "R9";
    do_load(1'b0, 1'b0, 5'd4, 5'd4, 32'h0);
    steps(40);

    cur = "R5";
    do_load(1'b1, 1'b1, 5'd3, 5'd9, 32'h1234_5678);
    cur = "R6"; track_run = 1'b1; run = 0; max_run = 0;
    steps(4000);
    track_run = 1'b0;
    check(max_run <= 14, "R6", max_run, 14);
    cur = "R10"; invert = 1'b1; steps(50); invert = 1'b0;

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule